// File: doc/BRIEF.md
# NAND Page Sector Layout Sequencer

This block walks through one NAND page as a series of error-correction sectors. It emits one tag for each byte moved across the flash data path, in either the read or the write direction. Every sector is laid out the same way: 512 bytes of user data, then an 8-byte free-data area, then a parity area. The size of the parity area comes from a coded spare-per-sector size. The surrounding controller asserts a byte strobe for each byte it moves. The sequencer answers with the slot kind, the current sector index and the byte position inside that sector.

A live completed-sector counter lets software poll for the end of the page. A done flag rises when the counter reaches the effective sector count. The free-data bytes of each sector are held in a bank of 64-bit entries that the host can reach as two 32-bit words. In write direction the bank supplies the free-data bytes to the stream. In read direction the bank captures them from the stream. The host can write the bank at any time. When a host write and a stream capture land on the same word in the same cycle, the host write wins.

Top module: `nand_sector_seq`

## Requirements
- R1: An active-low asynchronous reset, or a one-cycle `softReset` pulse, clears `sectorCnt`, `byteAddr`, `busy`, `dirWrite` and `done` by the next clock edge. `softReset` has priority over both start inputs.
- R2: While `busy` is high, `slotTag` is 1 (data) for byte positions 0 to 511 and 2 (free data) for positions 512 to 519. It is 3 (parity) for the remaining positions of the sector. While idle, `slotTag` is 0.
- R3: `spareCode` 0, 1, 2 and 3 select 16, 26, 27 and 28 spare bytes. A sector therefore spans 512 plus the spare size in bytes. The spare size is captured when a transfer starts.
- R4: Each `byteStep` during a transfer advances `byteAddr` by one. On the last byte of a sector, `byteAddr` returns to 0 and `sectorCnt` increases by one. After completion, `sectorCnt` holds its final value.
- R5: The effective sector count is `sectorReq` limited to the number of sectors in the page. `pageCode` 0 gives 1 sector, 1 gives 4 sectors, and 2 or 3 gives 8 sectors. When `sectorCnt` reaches the effective count, `busy` falls and `done` rises in the same edge.
- R6: A start while the effective count is 0 begins no transfer. `busy`, `sectorCnt` and `byteAddr` keep their values, and `done` is high after the next edge.
- R7: A start while idle sets `dirWrite` to 1 for `startWrite` and to 0 for `startRead`. If both are high, the write start wins. Start pulses while `busy` is high are ignored.
- R8: Free-data word index 2n holds bytes 0 to 3 of sector n, and index 2n+1 holds bytes 4 to 7. Byte 0 sits in bits 7:0. A host word write is visible on `fdmRdData` after the next edge.
- R9: In write direction during a free-data slot, `fdmByteOut` equals byte (`byteAddr` − 512) of the current sector's bank entry.
- R10: In read direction, a `byteStep` in a free-data slot stores `byteIn` into the matching bank byte. If a host write targets the same word in that cycle, the host value replaces the whole word. A host write to a different word does not block the capture.
- R11: A `byteStep` while idle changes neither `byteAddr` nor `sectorCnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| softReset | input | 1 | Synchronous clear of counters and direction state |
| startRead | input | 1 | Begin a read-direction transfer |
| startWrite | input | 1 | Begin a write-direction transfer |
| pageCode | input | 2 | Page size code (512 B, 2 KiB, 4 KiB) |
| spareCode | input | 2 | Spare-per-sector size code |
| sectorReq | input | 4 | Requested sector count |
| byteStep | input | 1 | One byte moved this cycle |
| byteIn | input | 8 | Byte arriving from the flash in read direction |
| fdmWrEn | input | 1 | Host write strobe for the free-data bank |
| fdmWrIdx | input | 4 | Host write word index |
| fdmWrData | input | 32 | Host write word |
| fdmRdIdx | input | 4 | Host read word index |
| fdmRdData | output | 32 | Host read word |
| slotTag | output | 2 | Slot kind of the current byte |
| sectorCnt | output | 4 | Completed-sector counter, also the current sector index |
| byteAddr | output | 10 | Byte position inside the current sector |
| busy | output | 1 | Transfer in progress |
| dirWrite | output | 1 | Direction of the last started transfer |
| done | output | 1 | Page transfer complete |
| fdmByteOut | output | 8 | Free-data byte for the current slot |

## Verification
In read direction, a stream capture of a free-data byte and a host write into the bank can fall in the same cycle. The bench provokes this twice. Once the host writes the very word that holds the byte being captured, on the last free-data byte of the sector. Once it writes an unrelated word while byte 1 is captured. Reading the bank back afterwards must show the host value as the complete first word, and both the captured byte and the host value where the words differ.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  localparam int SectorDataBytes = 512;
  localparam int FdmBytes        = 8;
  localparam int CntW            = 4;
  localparam int AddrW           = 10;
  localparam int LaneW           = $clog2(FdmBytes);
  localparam int SpareW          = 5;

  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_DATA   = 2'd1,
    SLOT_FDM    = 2'd2,
    SLOT_PARITY = 2'd3
  } slot_e;

  // Control-to-datapath strobes for the free-data bank.
  typedef struct packed {
    logic             capEn;
    logic [CntW-1:0]  sector;
    logic [LaneW-1:0] lane;
  } fdmStrobe_t;

  function automatic logic [SpareW-1:0] spareBytes(input logic [1:0] code);
    case (code)
      2'd0:    spareBytes = SpareW'(16);
      2'd1:    spareBytes = SpareW'(26);
      2'd2:    spareBytes = SpareW'(27);
      default: spareBytes = SpareW'(28);
    endcase
  endfunction

  function automatic logic [CntW-1:0] pageSectors(input logic [1:0] code);
    case (code)
      2'd0:    pageSectors = CntW'(1);
      2'd1:    pageSectors = CntW'(4);
      default: pageSectors = CntW'(8);
    endcase
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             softReset,
  input  logic             startRead,
  input  logic             startWrite,
  input  logic [1:0]       pageCode,
  input  logic [1:0]       spareCode,
  input  logic [CntW-1:0]  sectorReq,
  input  logic             byteStep,
  output logic [1:0]       slotTag,
  output logic [CntW-1:0]  sectorCnt,
  output logic [AddrW-1:0] byteAddr,
  output logic             busy,
  output logic             dirWrite,
  output logic             done,
  output fdmStrobe_t       strobe
);

  localparam logic [AddrW-1:0] FdmFirst  = AddrW'(SectorDataBytes);
  localparam logic [AddrW-1:0] ParFirst  = AddrW'(SectorDataBytes + FdmBytes);

  logic [SpareW-1:0] spareLat;
  logic [CntW-1:0]   target;
  logic [CntW-1:0]   effCount;
  logic [CntW-1:0]   pageMax;
  logic [AddrW-1:0]  lastAddr;
  logic              startAny;
  slot_e             slot;

  always_comb begin
    pageMax  = pageSectors(pageCode);
    effCount = (sectorReq > pageMax) ? pageMax : sectorReq;
    startAny = startRead | startWrite;
    lastAddr = FdmFirst + AddrW'(spareLat) - AddrW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dirWrite  <= 1'b0;
      done      <= 1'b0;
      sectorCnt <= '0;
      byteAddr  <= '0;
      target    <= '0;
      spareLat  <= '0;
    end else if (softReset) begin
      busy      <= 1'b0;
      dirWrite  <= 1'b0;
      done      <= 1'b0;
      sectorCnt <= '0;
      byteAddr  <= '0;
    end else if (!busy && startAny) begin
      if (effCount == '0) begin
        done <= 1'b1;
      end else begin
        busy      <= 1'b1;
        dirWrite  <= startWrite;
        done      <= 1'b0;
        sectorCnt <= '0;
        byteAddr  <= '0;
        target    <= effCount;
        spareLat  <= spareBytes(spareCode);
      end
    end else if (busy && byteStep) begin
      if (byteAddr == lastAddr) begin
        byteAddr  <= '0;
        sectorCnt <= sectorCnt + CntW'(1);
        if ((sectorCnt + CntW'(1)) == target) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        byteAddr <= byteAddr + AddrW'(1);
      end
    end
  end

  always_comb begin
    if (!busy)                  slot = SLOT_IDLE;
    else if (byteAddr < FdmFirst) slot = SLOT_DATA;
    else if (byteAddr < ParFirst) slot = SLOT_FDM;
    else                        slot = SLOT_PARITY;
  end

  assign slotTag       = slot;
  assign strobe.capEn  = busy & ~dirWrite & byteStep & (slot == SLOT_FDM);
  assign strobe.sector = sectorCnt;
  assign strobe.lane   = byteAddr[LaneW-1:0];

  p_addr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byteAddr <= lastAddr));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sectorCnt < target));

  p_finish_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(softReset)) |-> done);

  p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> (!busy && !done && !dirWrite && sectorCnt == '0 && byteAddr == '0));

  p_zero_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !softReset && startAny && effCount == '0) |=> (done && !busy));

  p_idle_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && byteStep && !startAny && !softReset) |=> ($stable(byteAddr) && $stable(sectorCnt)));

endmodule

// File: rtl/fdm_bank.sv
`timescale 1ns/1ps
module fdm_bank
  import nand_seq_pkg::*;
#(
  parameter int MaxSectors = 8,
  localparam int BankIdxW  = $clog2(MaxSectors),
  localparam int EntryW    = FdmBytes * 8,
  localparam int WordW     = EntryW / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fdmStrobe_t          strobe,
  input  logic [7:0]          byteIn,
  input  logic                hostWrEn,
  input  logic [BankIdxW:0]   hostWrIdx,
  input  logic [WordW-1:0]    hostWrData,
  input  logic [BankIdxW:0]   hostRdIdx,
  output logic [WordW-1:0]    hostRdData,
  output logic [7:0]          byteOut
);

  logic [EntryW-1:0] bank [MaxSectors];

  logic [BankIdxW-1:0] capSec;
  logic [BankIdxW-1:0] hostSec;
  logic                capHalf;
  logic                collide;

  always_comb begin
    capSec  = strobe.sector[BankIdxW-1:0];
    capHalf = strobe.lane[LaneW-1];
    hostSec = hostWrIdx[BankIdxW:1];
    collide = hostWrEn && (hostSec == capSec) && (hostWrIdx[0] == capHalf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MaxSectors; i++) bank[i] <= '0;
    end else begin
      if (strobe.capEn && !collide)
        bank[capSec][{strobe.lane, 3'b000} +: 8] <= byteIn;
      if (hostWrEn)
        bank[hostSec][{hostWrIdx[0], 5'b00000} +: WordW] <= hostWrData;
    end
  end

  assign hostRdData = bank[hostRdIdx[BankIdxW:1]][{hostRdIdx[0], 5'b00000} +: WordW];
  assign byteOut    = bank[capSec][{strobe.lane, 3'b000} +: 8];

  function automatic logic [WordW-1:0] wordAt(input logic [BankIdxW:0] idx);
    return bank[idx[BankIdxW:1]][{idx[0], 5'b00000} +: WordW];
  endfunction

  // Host write lands whole, even against a same-cycle capture (R8, R10).
  p_host_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hostWrEn |=> (wordAt($past(hostWrIdx)) == $past(hostWrData)));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capEn && !hostWrEn) |=>
      (bank[$past(capSec)][{$past(strobe.lane), 3'b000} +: 8] == $past(byteIn)));

endmodule

// File: rtl/nand_sector_seq.sv
`timescale 1ns/1ps
module nand_sector_seq
  import nand_seq_pkg::*;
#(
  parameter int MaxSectors = 8,
  localparam int BankIdxW  = $clog2(MaxSectors)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                softReset,
  input  logic                startRead,
  input  logic                startWrite,
  input  logic [1:0]          pageCode,
  input  logic [1:0]          spareCode,
  input  logic [3:0]          sectorReq,
  input  logic                byteStep,
  input  logic [7:0]          byteIn,
  input  logic                fdmWrEn,
  input  logic [BankIdxW:0]   fdmWrIdx,
  input  logic [31:0]         fdmWrData,
  input  logic [BankIdxW:0]   fdmRdIdx,
  output logic [31:0]         fdmRdData,
  output logic [1:0]          slotTag,
  output logic [3:0]          sectorCnt,
  output logic [9:0]          byteAddr,
  output logic                busy,
  output logic                dirWrite,
  output logic                done,
  output logic [7:0]          fdmByteOut
);

  fdmStrobe_t strobe;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .softReset  (softReset),
    .startRead  (startRead),
    .startWrite (startWrite),
    .pageCode   (pageCode),
    .spareCode  (spareCode),
    .sectorReq  (sectorReq),
    .byteStep   (byteStep),
    .slotTag    (slotTag),
    .sectorCnt  (sectorCnt),
    .byteAddr   (byteAddr),
    .busy       (busy),
    .dirWrite   (dirWrite),
    .done       (done),
    .strobe     (strobe)
  );

  fdm_bank #(.MaxSectors(MaxSectors)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .byteIn     (byteIn),
    .hostWrEn   (fdmWrEn),
    .hostWrIdx  (fdmWrIdx),
    .hostWrData (fdmWrData),
    .hostRdIdx  (fdmRdIdx),
    .hostRdData (fdmRdData),
    .byteOut    (fdmByteOut)
  );

endmodule

// File: tb/nand_sector_seq_test.sv
`timescale 1ns/1ps
module nand_sector_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic softReset = 0, startRead = 0, startWrite = 0, byteStep = 0, fdmWrEn = 0;
  logic [1:0] pageCode = 0, spareCode = 0;
  logic [3:0] sectorReq = 0, fdmWrIdx = 0, fdmRdIdx = 0;
  logic [7:0] byteIn = 0;
  logic [31:0] fdmWrData = 0, fdmRdData;
  logic [1:0] slotTag;
  logic [3:0] sectorCnt;
  logic [9:0] byteAddr;
  logic busy, dirWrite, done;
  logic [7:0] fdmByteOut;

  always #4 clk = ~clk;

  nand_sector_seq uut (.*);

  typedef struct {
    logic [15:0] pos;
    bit          fdmChk;
    logic [7:0]  fdmExp;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  int spareTab[4] = '{16, 26, 27, 28};
  logic [7:0] fdmModel[8][8];
  int colAddrA = -1, colIdxA = 0;
  int colAddrB = -1, colIdxB = 0;
  logic [31:0] colDataA = 0, colDataB = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int a);
    return 8'((s * 37 + a * 3) & 255);
  endfunction

  function automatic logic [1:0] tagOf(input int a);
    if (a < 512) return 2'd1;
    if (a < 520) return 2'd2;
    return 2'd3;
  endfunction

  // Scoreboard monitor: compares each moved byte against the queued expectation.
  always @(negedge clk) begin
    if (byteStep && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({slotTag, sectorCnt, byteAddr} == it.pos, "R2 R3 R4 slot/sector/addr",
          {slotTag, sectorCnt, byteAddr}, it.pos);
      if (it.fdmChk)
        chk(fdmByteOut == it.fdmExp, "R9 fdmByteOut", fdmByteOut, it.fdmExp);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic startPulse(input bit r, input bit w, input logic [1:0] pc,
                            input logic [1:0] sc, input logic [3:0] req);
    pageCode = pc; spareCode = sc; sectorReq = req; startRead = r; startWrite = w;
    cyc();
    startRead = 0; startWrite = 0;
  endtask

  // Driver: one byte per cycle, pushes the expected tag for each.
  task automatic runSteps(input bit isWrite, input int sc, input int eff, input int limit);
    int len = 512 + spareTab[sc];
    int n = 0;
    for (int s = 0; s < eff; s++) begin
      for (int a = 0; a < len; a++) begin
        if (n < limit) begin
          item_t it;
          it.pos    = {tagOf(a), 4'(s), 10'(a)};
          it.fdmChk = isWrite && (tagOf(a) == 2'd2);
          it.fdmExp = it.fdmChk ? fdmModel[s][a - 512] : 8'h00;
          q.push_back(it);
          byteStep = 1; byteIn = pat(s, a);
          if (s == 0 && a == colAddrA) begin fdmWrEn = 1; fdmWrIdx = 4'(colIdxA); fdmWrData = colDataA; end
          if (s == 0 && a == colAddrB) begin fdmWrEn = 1; fdmWrIdx = 4'(colIdxB); fdmWrData = colDataB; end
          cyc();
          fdmWrEn = 0;
          n++;
        end
      end
    end
    byteStep = 0;
  endtask

  task automatic hostWrite(input int idx, input logic [31:0] d);
    fdmWrEn = 1; fdmWrIdx = 4'(idx); fdmWrData = d;
    cyc();
    fdmWrEn = 0;
    for (int L = 0; L < 4; L++) fdmModel[idx / 2][(idx % 2) * 4 + L] = d[L*8 +: 8];
  endtask

  task automatic readWord(input int idx, output logic [31:0] d);
    fdmRdIdx = 4'(idx);
    @(negedge clk);
    d = fdmRdData;
    cyc();
  endtask

  function automatic logic [31:0] patWord(input int s, input int half);
    return {pat(s, 515 + half*4), pat(s, 514 + half*4), pat(s, 513 + half*4), pat(s, 512 + half*4)};
  endfunction

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    for (int s = 0; s < 8; s++) for (int L = 0; L < 8; L++) fdmModel[s][L] = 0;

    // Reset state (R1)
    #20; @(negedge clk);
    chk({busy, done, dirWrite, slotTag, sectorCnt, byteAddr} == 0, "R1 reset state",
        {busy, done, dirWrite, slotTag, sectorCnt, byteAddr}, 0);
    rst_n = 1; cyc();

    // Idle step ignored (R11)
    byteStep = 1; cyc(); byteStep = 0;
    @(negedge clk);
    chk({slotTag, sectorCnt, byteAddr} == 0, "R11 idle step", {slotTag, sectorCnt, byteAddr}, 0);
    cyc();

    // Host bank writes and word mapping (R8)
    for (int i = 0; i < 8; i++) hostWrite(i, 32'h1000_0000 * (i + 1) + 32'h0003_0201 * (i + 7));
    readWord(5, w);
    chk(w == {fdmModel[2][7], fdmModel[2][6], fdmModel[2][5], fdmModel[2][4]}, "R8 word 5", w,
        {fdmModel[2][7], fdmModel[2][6], fdmModel[2][5], fdmModel[2][4]});
    readWord(0, w);
    chk(w[7:0] == fdmModel[0][0], "R8 byte0 lsb", w[7:0], fdmModel[0][0]);

    // Write direction, 2 KiB page, spare 26, 4 sectors (R2 R3 R4 R9 R7)
    startPulse(0, 1, 2'd1, 2'd1, 4'd4);
    @(negedge clk);
    chk(busy && dirWrite, "R7 write start", {busy, dirWrite}, 2'b11);
    cyc();
    runSteps(1, 1, 4, 100000);
    @(negedge clk);
    chk({busy, done, sectorCnt, slotTag} == {1'b0, 1'b1, 4'd4, 2'd0}, "R5 R4 write done",
        {busy, done, sectorCnt, slotTag}, {1'b0, 1'b1, 4'd4, 2'd0});
    cyc();

    // Read direction, 512 B page clips request 5 to 1, spare 28, with collisions (R5 R10 R7)
    colAddrA = 519; colIdxA = 1; colDataA = 32'hCAFE_F00D;
    colAddrB = 513; colIdxB = 3; colDataB = 32'h1357_2468;
    startPulse(1, 0, 2'd0, 2'd3, 4'd5);
    @(negedge clk);
    chk(busy && !dirWrite, "R7 read start", {busy, dirWrite}, 2'b10);
    cyc();
    runSteps(0, 3, 1, 100000);
    colAddrA = -1; colAddrB = -1;
    @(negedge clk);
    chk({busy, done, sectorCnt} == {1'b0, 1'b1, 4'd1}, "R5 page clip", {busy, done, sectorCnt}, {1'b0, 1'b1, 4'd1});
    cyc();
    readWord(0, w); chk(w == patWord(0, 0), "R10 capture word0", w, patWord(0, 0));
    readWord(1, w); chk(w == 32'hCAFE_F00D, "R10 host wins collision", w, 32'hCAFE_F00D);
    readWord(3, w); chk(w == 32'h1357_2468, "R10 other word write", w, 32'h1357_2468);

    // Read, 4 KiB page, spare 27, 2 sectors (R3 R10)
    startPulse(1, 0, 2'd2, 2'd2, 4'd2); cyc();
    runSteps(0, 2, 2, 100000);
    @(negedge clk);
    chk({done, sectorCnt} == {1'b1, 4'd2}, "R5 two sectors", {done, sectorCnt}, {1'b1, 4'd2});
    cyc();
    readWord(2, w); chk(w == patWord(1, 0), "R10 sector1 low", w, patWord(1, 0));
    readWord(3, w); chk(w == patWord(1, 1), "R10 sector1 high", w, patWord(1, 1));

    // Page code 3, request 9 clipped to 8, spare 16 (R5 R3)
    startPulse(1, 0, 2'd3, 2'd0, 4'd9); cyc();
    runSteps(0, 0, 8, 100000);
    @(negedge clk);
    chk({busy, done, sectorCnt} == {1'b0, 1'b1, 4'd8}, "R5 eight sectors", {busy, done, sectorCnt}, {1'b0, 1'b1, 4'd8});
    cyc();
    readWord(15, w); chk(w == patWord(7, 1), "R10 sector7 high", w, patWord(7, 1));

    // Both starts -> write; start while busy ignored (R7)
    startPulse(1, 1, 2'd1, 2'd0, 4'd4);
    startRead = 1; cyc(); startRead = 0;
    @(negedge clk);
    chk({busy, dirWrite, byteAddr} == {1'b1, 1'b1, 10'd0}, "R7 busy start ignored",
        {busy, dirWrite, byteAddr}, {1'b1, 1'b1, 10'd0});
    cyc();
    for (int s = 0; s < 8; s++) for (int L = 0; L < 8; L++) fdmModel[s][L] = 8'hxx;
    runSteps(0, 0, 4, 600);
    q.delete();
    @(negedge clk);
    chk({sectorCnt, byteAddr} == {4'd1, 10'd72}, "R4 mid transfer", {sectorCnt, byteAddr}, {4'd1, 10'd72});
    cyc();

    // Soft reset mid-transfer (R1)
    softReset = 1; cyc(); softReset = 0;
    @(negedge clk);
    chk({busy, done, dirWrite, sectorCnt, byteAddr} == 0, "R1 soft reset",
        {busy, done, dirWrite, sectorCnt, byteAddr}, 0);
    cyc();

    // Zero count start (R6)
    startPulse(0, 1, 2'd2, 2'd1, 4'd0);
    @(negedge clk);
    chk({busy, done, dirWrite, sectorCnt, byteAddr} == {1'b0, 1'b1, 1'b0, 4'd0, 10'd0}, "R6 zero count",
        {busy, done, dirWrite, sectorCnt, byteAddr}, {1'b0, 1'b1, 1'b0, 4'd0, 10'd0});
    cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule